// File: doc/BRIEF.md
# Multi-Input Wake-Up Edge Capture

The block watches a set of asynchronous wake-up lines, split into banks of 32, and remembers per line whether a rising edge and whether a falling edge has been seen since software last cleared it. Every line is resynchronised through two flops. An edge is then found by comparing the synchronised sample with the sample one cycle older. Each detected edge sets a sticky pending bit in the rising or the falling pending word of its bank.

Software reaches the pending words over a simple word-wide register bus. Access is single-cycle and read data comes back one cycle after the request. Each bank also has a write-only clear word. A 1 written to bit n of the clear word drops bit n of both that bank's rising and falling pending words in the same cycle. A registered request output goes high while any pending bit in any bank is set. It serves as a combined wake and interrupt line.

Top module: `wake_edge_capture`

## Requirements
- R1: After reset every pending bit is 0, `wake_req_o` is 0, `rvalid_o` is 0 and `rdata_o` is 0.
- R2: A rising edge on wake line 32*b+n sets bit n of the rising pending word of bank b. Bank b's rising word is at byte offset 0x00+4*b. The bit stays 1 until it is cleared or overwritten.
- R3: A falling edge on wake line 32*b+n sets bit n of the falling pending word of bank b. Bank b's falling word is at byte offset 0x08+4*b. The bit stays 1 until it is cleared or overwritten.
- R4: Let a level change on a wake line first be sampled at clock edge k. The matching pending bit becomes 1 at edge k+2, and a read sampled at edge k+2 still returns the old value.
- R5: A write to the clear word of bank b (offset 0x10+4*b) clears every bit set to 1 in the data in both the rising and the falling pending word of bank b. Bits written as 0 are left unchanged.
- R6: A clear write to one bank leaves the pending words of every other bank unchanged.
- R7: A write to a rising or falling pending word loads the written data into it.
- R8: If an edge is detected on a line in the same cycle that a clear or a load writes 0 to its pending bit, the bit ends up 1.
- R9: Reading a clear word returns 0. Reads of offsets above 0x14 return 0, and writes to them change nothing.
- R10: `wake_req_o` equals, one cycle late, the OR of all rising and falling pending bits of all banks.
- R11: A read request sampled at a clock edge drives `rvalid_o`=1 and the pending value as it stood before that edge onto `rdata_o` in the following cycle. In cycles with no read, `rvalid_o` and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | 64 | Asynchronous wake-up lines, bank b holds lines 32*b+31..32*b |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 5 | Byte address, bits 1:0 ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| rvalid_o | output | 1 | Read data valid |
| wake_req_o | output | 1 | Registered OR of all pending bits |

## Verification
The bench aims at the cycle in which an edge and a clear meet on the same bit. A design that let the clear win would silently lose a wake event. Bank isolation is tested by clearing one bank while the other holds pending bits. A decoder that ignored the bank index would wipe both. The two-flop latency is checked with reads placed exactly at the edge where the bit appears, so an extra or missing stage shows up as a one-cycle shift. Unmapped and clear-word reads must return 0, and random mixed traffic is compared every cycle against a behavioural model to expose stale read data or a late request line.

// File: rtl/wec_pkg.sv
package wec_pkg;
  localparam int unsigned KIND_RISE = 0;
  localparam int unsigned KIND_FALL = 1;
  localparam int unsigned KIND_CLR  = 2;
  localparam int unsigned NUM_KINDS = 3;
endpackage

// File: rtl/wec_sync.sv
module wec_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/wec_bank.sv
module wec_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_edge_i,
  input  logic [W-1:0] fall_edge_i,
  input  logic         rise_we_i,
  input  logic         fall_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] rise_q, fall_q, rise_d, fall_d, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  // edge set is ORed last so it beats clear and load
  always_comb begin
    rise_d = rise_we_i ? wdata_i : (rise_q & ~clr_mask);
    fall_d = fall_we_i ? wdata_i : (fall_q & ~clr_mask);
    rise_d = rise_d | rise_edge_i;
    fall_d = fall_d | fall_edge_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;

  assert_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> (((rise_q & $past(wdata_i) & ~$past(rise_edge_i)) == '0) &&
                  ((fall_q & $past(wdata_i) & ~$past(fall_edge_i)) == '0)));

  assert_rise_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_we_i && !clr_we_i) |=> ((rise_q & $past(rise_q)) == $past(rise_q)));

  assert_fall_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_we_i && !clr_we_i) |=> ((fall_q & $past(fall_q)) == $past(fall_q)));

  assert_rise_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_edge_i) |=> ((rise_q & $past(rise_edge_i)) == $past(rise_edge_i)));

  assert_fall_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fall_edge_i) |=> ((fall_q & $past(fall_edge_i)) == $past(fall_edge_i)));
endmodule

// File: rtl/wec_regif.sv
module wec_regif
  import wec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = $clog2(NUM_KINDS*NUM_BANKS) + 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                req_i,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]    rise_i,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]    fall_i,
  output logic [NUM_BANKS-1:0]                rise_we_o,
  output logic [NUM_BANKS-1:0]                fall_we_o,
  output logic [NUM_BANKS-1:0]                clr_we_o,
  output logic [BANK_W-1:0]                   rdata_o,
  output logic                                rvalid_o
);
  localparam int unsigned WORD_W  = ADDR_W - 2;
  localparam int unsigned NUM_REG = NUM_KINDS * NUM_BANKS;
  localparam int unsigned BIDX_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [WORD_W-1:0] word;
  int unsigned       widx, kind;
  logic [BIDX_W-1:0] bidx;
  logic              mapped, wr, rd, unused_lsb;
  logic [BANK_W-1:0] rd_mux, rdata_q;
  logic              rvalid_q;

  assign word       = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign wr         = req_i && we_i;
  assign rd         = req_i && !we_i;

  always_comb begin
    widx   = 32'(word);
    mapped = widx < NUM_REG;
    kind   = widx / NUM_BANKS;
    bidx   = BIDX_W'(widx % NUM_BANKS);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign rise_we_o[b] = wr && mapped && (kind == KIND_RISE) && (bidx == BIDX_W'(b));
    assign fall_we_o[b] = wr && mapped && (kind == KIND_FALL) && (bidx == BIDX_W'(b));
    assign clr_we_o[b]  = wr && mapped && (kind == KIND_CLR)  && (bidx == BIDX_W'(b));
  end

  always_comb begin
    rd_mux = '0;
    if (mapped) begin
      if (kind == KIND_RISE)      rd_mux = rise_i[bidx];
      else if (kind == KIND_FALL) rd_mux = fall_i[bidx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      rdata_q  <= rd ? rd_mux : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  assert_rvalid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);

  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> (!rvalid_o && rdata_o == '0));

  assert_clr_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (!mapped || kind == KIND_CLR)) |=> (rdata_o == '0));

  assert_wr_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_we_o, fall_we_o, clr_we_o}));
endmodule

// File: rtl/wake_edge_capture.sv
module wake_edge_capture
  import wec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = $clog2(NUM_KINDS*NUM_BANKS) + 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_BANKS*BANK_W-1:0]   wake_i,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [BANK_W-1:0]             wdata_i,
  output logic [BANK_W-1:0]             rdata_o,
  output logic                          rvalid_o,
  output logic                          wake_req_o
);
  localparam int unsigned NUM_IN = NUM_BANKS * BANK_W;

  logic [NUM_IN-1:0]                 rise_flat, fall_flat;
  logic [NUM_BANKS-1:0][BANK_W-1:0]  rise_edge, fall_edge, rise_pend, fall_pend;
  logic [NUM_BANKS-1:0]              rise_we, fall_we, clr_we;
  logic                              req_q;

  wec_sync #(.W(NUM_IN)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (wake_i),
    .rise_o  (rise_flat),
    .fall_o  (fall_flat)
  );

  assign rise_edge = rise_flat;
  assign fall_edge = fall_flat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wec_bank #(.W(BANK_W)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rise_edge_i (rise_edge[b]),
      .fall_edge_i (fall_edge[b]),
      .rise_we_i   (rise_we[b]),
      .fall_we_i   (fall_we[b]),
      .clr_we_i    (clr_we[b]),
      .wdata_i     (wdata_i),
      .rise_o      (rise_pend[b]),
      .fall_o      (fall_pend[b])
    );
  end

  wec_regif #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
  ) u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .rise_i    (rise_pend),
    .fall_i    (fall_pend),
    .rise_we_o (rise_we),
    .fall_we_o (fall_we),
    .clr_we_o  (clr_we),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= (|rise_pend) || (|fall_pend);
  end

  assign wake_req_o = req_q;

  assert_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (wake_req_o == $past((|rise_pend) || (|fall_pend))));
endmodule

// File: tb/wake_edge_capture_bench.sv
module wake_edge_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wake = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, wake_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wake_edge_capture u_wake_edge_capture (
    .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .wake_req_o(wake_req)
  );

  // behavioural reference model
  bit [63:0] m1, m2, m3, mr, mf;
  bit [31:0] mrdata;
  bit        mrv, mreq;

  always @(posedge clk) begin
    bit [63:0] re, fe, nr, nf;
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; mr = 0; mf = 0; mrdata = 0; mrv = 0; mreq = 0;
    end else begin
      re = m2 & ~m3;
      fe = m3 & ~m2;
      mreq = (mr != 0) || (mf != 0);
      mrv = req && !we;
      mrdata = 0;
      if (mrv) begin
        case (addr[4:2])
          3'd0: mrdata = mr[31:0];
          3'd1: mrdata = mr[63:32];
          3'd2: mrdata = mf[31:0];
          3'd3: mrdata = mf[63:32];
          default: mrdata = 0;
        endcase
      end
      nr = mr; nf = mf;
      if (req && we) begin
        case (addr[4:2])
          3'd0: nr[31:0]  = wdata;
          3'd1: nr[63:32] = wdata;
          3'd2: nf[31:0]  = wdata;
          3'd3: nf[63:32] = wdata;
          3'd4: begin nr[31:0] &= ~wdata; nf[31:0] &= ~wdata; end
          3'd5: begin nr[63:32] &= ~wdata; nf[63:32] &= ~wdata; end
          default: ;
        endcase
      end
      mr = nr | re; mf = nf | fe;
      m3 = m2; m2 = m1; m1 = wake;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R11 rdata model", rdata, mrdata);
    chk("R11 rvalid model", {31'd0, rvalid}, {31'd0, mrv});
    chk("R10 wake_req model", {31'd0, wake_req}, {31'd0, mreq});
  end

  // tasks are entered at a negedge and leave at the next one
  task automatic wr(logic [4:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    req = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset wake_req", {31'd0, wake_req}, 32'd0);
    chk("R1 reset rvalid", {31'd0, rvalid}, 32'd0);
    chk("R1 reset rdata", rdata, 32'd0);
    rst_n = 1;
    @(negedge clk);
    rd(5'h00, 32'h0, "R1 rise bank0");
    rd(5'h0C, 32'h0, "R1 fall bank1");

    // R2 rising edges in both banks
    wake[3] = 1; wake[40] = 1;
    repeat (4) @(negedge clk);
    rd(5'h00, 32'h0000_0008, "R2 rise bank0 bit3");
    rd(5'h04, 32'h0000_0100, "R2 rise bank1 bit8");
    chk("R10 wake_req set", {31'd0, wake_req}, 32'd1);

    // R3 falling edges, rising stays sticky
    wake[3] = 0; wake[40] = 0;
    repeat (4) @(negedge clk);
    rd(5'h08, 32'h0000_0008, "R3 fall bank0 bit3");
    rd(5'h00, 32'h0000_0008, "R2 rise sticky");

    // R5 clear both kinds in bank0; R6 bank1 untouched
    wr(5'h10, 32'h0000_0008);
    rd(5'h00, 32'h0, "R5 rise cleared");
    rd(5'h08, 32'h0, "R5 fall cleared");
    rd(5'h04, 32'h0000_0100, "R6 bank1 rise kept");
    rd(5'h0C, 32'h0000_0100, "R6 bank1 fall kept");
    wr(5'h14, 32'h0000_0001);
    rd(5'h04, 32'h0000_0100, "R5 zero bits unchanged");

    // R7 load pending word
    wr(5'h0C, 32'hA5A5_0000);
    rd(5'h0C, 32'hA5A5_0000, "R7 load fall bank1");
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h04, 32'h0, "R5 bank1 rise all cleared");
    rd(5'h0C, 32'h0, "R5 bank1 fall all cleared");
    @(negedge clk);
    chk("R10 wake_req cleared", {31'd0, wake_req}, 32'd0);

    // R4 latency: change sampled at edge k, bit set at k+2
    wake[5] = 1;
    @(negedge clk);
    @(negedge clk);
    rd(5'h00, 32'h0, "R4 read at k+2 sees old");
    chk("R4 wake_req not yet", {31'd0, wake_req}, 32'd0);
    rd(5'h00, 32'h0000_0020, "R4 bit visible after k+2");
    chk("R10 wake_req one cycle late", {31'd0, wake_req}, 32'd1);

    // R8 falling edge detected in the clear cycle
    wake[5] = 0;
    @(negedge clk);
    @(negedge clk);
    wr(5'h10, 32'h0000_0020);
    rd(5'h08, 32'h0000_0020, "R8 fall set beats clear");
    rd(5'h00, 32'h0, "R8 rise bit cleared");

    // R9 clear word and unmapped reads, unmapped writes
    rd(5'h10, 32'h0, "R9 clear word reads zero");
    rd(5'h18, 32'h0, "R9 unmapped read zero");
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h08, 32'h0000_0020, "R9 unmapped write ignored");
    rd(5'h00, 32'h0, "R9 unmapped write no load");

    // random mixed traffic, compared against the model every cycle
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) wake[$urandom_range(0, 63)] ^= 1'b1;
      req   = ($urandom_range(0, 1) == 1);
      we    = ($urandom_range(0, 3) == 0);
      addr  = 5'($urandom_range(0, 7) << 2);
      wdata = $urandom();
      @(negedge clk);
    end
    req = 0; we = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule